// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block stores the routing setup of an I/O interrupt controller and makes it reachable through an indirect access pair. Software first writes an 8-bit index into a select register. It then reads or writes a 32-bit data window, and the block steers that access to the location the index names. The indexed locations are an identification word, a version word and one 64-bit routing entry per interrupt pin. Each routing entry is reached as two 32-bit halves. A third bus offset accepts end-of-interrupt notices carrying a vector number.

The decoded fields of every entry leave the block on flat per-pin buses for the interrupt service logic: vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. The service logic tells the block when a level-triggered interrupt has been handed on, which sets the entry's remote-pending flag. The block reports each change to a mask bit. It also asks for service when a write or an end-of-interrupt leaves a level-triggered, unmasked pin with its input pending.

Top module: `irq_route_regfile`

## Requirements
- R1: Bus offset 0x00 holds the select register. A write there keeps only bits 7:0 of the data, and a read there returns the select value zero-extended to 32 bits.
- R2: A window access with select 0x01 reaches the version word, which reads as {8'h00, NUM_PINS-1, 8'h00, VERSION_CODE}. Window writes at this select change nothing.
- R3: Window select 0x00 reaches a 4-bit identification field held in bits 27:24. A write there stores data bits 27:24, and reads at select 0x00 and at select 0x02 both return {4'b0, id, 24'b0}. Window writes at select 0x02 change nothing.
- R4: A select s of 0x10 or above names entry (s-0x10)>>1. An odd s reaches the high half, where the destination sits in bits 31:24 and the other bits read 0. An even s reaches the low half: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14 (read-only), trigger 15 (1 = level) and mask 16, with all other bits reading 0. The same values appear on the per-pin outputs.
- R5: A pulse on rirr_set[p] sets the remote-pending flag of pin p. A window write to the low half of entry p clears it, and this clear wins over a set in the same cycle. A write to the high half leaves it unchanged.
- R6: Window writes to an entry index at or beyond NUM_PINS change nothing. Window reads there, and at selects 0x03 to 0x0F, return 0.
- R7: While reset is asserted, every entry has its mask bit at 1 and all other fields at 0. The select register and the identification field are 0, and bus_rvalid, mask_evt and svc_req are low.
- R8: One cycle after a window write that changes an entry's mask bit, mask_evt is high for one cycle, with mask_evt_pin giving the pin and mask_evt_val giving the new mask. A write that leaves the mask unchanged raises no event.
- R9: One cycle after a window write to entry p, svc_req[p] pulses if the entry is then level-triggered and unmasked and pin_pend[p] is high. An edge-triggered or masked entry gives no pulse.
- R10: A write at bus offset 0x40 carries a vector in data bits 7:0. Every level-triggered entry with that vector has its remote-pending flag cleared. One cycle later, svc_req pulses for each such entry that is unmasked with its pin pending. Entries with another vector keep their flag.
- R11: Bus accesses at offsets other than 0x00, 0x10 and 0x40 have no effect, and reads there, as at 0x40, return 0.
- R12: Read data is registered. bus_rvalid is high in the cycle after bus_rd, and bus_rdata holds the value in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the bus access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_pend | input | NUM_PINS | Per-pin pending input level |
| rirr_set | input | NUM_PINS | Per-pin pulse that sets remote-pending |
| rt_vector | output | 8*NUM_PINS | Vector of each pin |
| rt_dlv | output | 3*NUM_PINS | Delivery mode of each pin |
| rt_dmode | output | NUM_PINS | Destination mode of each pin |
| rt_pol | output | NUM_PINS | Polarity of each pin |
| rt_trig | output | NUM_PINS | Trigger mode of each pin (1 = level) |
| rt_mask | output | NUM_PINS | Mask of each pin |
| rt_rirr | output | NUM_PINS | Remote-pending flag of each pin |
| rt_dest | output | 8*NUM_PINS | Destination of each pin |
| mask_evt | output | 1 | Mask-change event strobe |
| mask_evt_pin | output | $clog2(NUM_PINS) | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | NUM_PINS | Per-pin service request pulses |

## Verification
The bench builds the block with NUM_PINS set to 6 and VERSION_CODE set to 8'h21. With only six pins, most of the 256 select values fall past the last entry. A full sweep of every select can then read back the identification, version, both halves of each entry and the out-of-range zeros, and a second sweep writes ones to every unused index. The small pin count also lets the event tests reach a level pin, an edge pin, a masked pin and a pin with another vector in a few writes. This covers the mask-event, service and end-of-interrupt rules against one another.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

  // one routing entry, only the implemented fields
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;   // 1 = level
    logic       rirr;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vector;
  } rte_t;

  localparam rte_t RTE_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, rirr: 1'b0,
                               pol: 1'b0, dmode: 1'b0, dlv: 3'b000, vector: 8'h00};

  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_RTE_BASE = 8'h10;

  // low half of an entry as seen through the window
  function automatic logic [31:0] rte_lo_word(rte_t e);
    return {15'b0, e.mask, e.trig, e.rirr, e.pol, 1'b0, e.dmode, e.dlv, e.vector};
  endfunction

  function automatic logic [31:0] rte_hi_word(rte_t e);
    return {e.dest, 24'b0};
  endfunction

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode #(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  parameter int OFS_SEL  = 'h00,
  parameter int OFS_WIN  = 'h10,
  parameter int OFS_EOI  = 'h40,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        sel,
  output logic              hit_sel,
  output logic              hit_win,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              eoi_wr,
  output logic              acc_id,
  output logic              acc_ver,
  output logic              acc_arb,
  output logic              acc_rte,
  output logic              rte_hi,
  output logic [PIN_W-1:0]  rte_idx
);
  import irq_rf_pkg::*;

  localparam logic [6:0] NP7 = 7'(NUM_PINS);

  logic       hit_eoi;
  logic [6:0] idx7;

  assign hit_sel = (bus_addr == ADDR_W'(OFS_SEL));
  assign hit_win = (bus_addr == ADDR_W'(OFS_WIN));
  assign hit_eoi = (bus_addr == ADDR_W'(OFS_EOI));

  assign sel_wr = bus_wr & hit_sel;
  assign win_wr = bus_wr & hit_win;
  assign eoi_wr = bus_wr & hit_eoi;

  assign acc_id  = (sel == SEL_ID);
  assign acc_ver = (sel == SEL_VER);
  assign acc_arb = (sel == SEL_ARB);

  // entry index = (sel - base) / 2
  assign idx7    = sel[7:1] - SEL_RTE_BASE[7:1];
  assign acc_rte = (sel >= SEL_RTE_BASE) && (idx7 < NP7);
  assign rte_hi  = sel[0];
  assign rte_idx = idx7[PIN_W-1:0];

endmodule

// File: rtl/irq_rf_entry.sv
module irq_rf_entry (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [31:0]        wdata,
  input  logic               eoi_wr,
  input  logic [7:0]         eoi_vec,
  input  logic               rirr_set,
  input  logic               pin_pend,
  output irq_rf_pkg::rte_t   rte,
  output logic               mask_chg,
  output logic               svc
);
  import irq_rf_pkg::*;

  rte_t cur_q, cur_d;
  logic chg_q, chg_d;
  logic svc_q, svc_d;
  logic eoi_hit;
  logic any_wr;

  assign any_wr  = wr_lo | wr_hi;
  assign eoi_hit = eoi_wr && cur_q.trig && (cur_q.vector == eoi_vec);

  always_comb begin
    cur_d = cur_q;
    if (wr_lo) begin
      cur_d.vector = wdata[7:0];
      cur_d.dlv    = wdata[10:8];
      cur_d.dmode  = wdata[11];
      cur_d.pol    = wdata[13];
      cur_d.trig   = wdata[15];
      cur_d.mask   = wdata[16];
    end
    if (wr_hi) begin
      cur_d.dest = wdata[31:24];
    end
    if (rirr_set) begin
      cur_d.rirr = 1'b1;
    end
    if (wr_lo || eoi_hit) begin
      cur_d.rirr = 1'b0;
    end
    chg_d = any_wr && (cur_d.mask != cur_q.mask);
    svc_d = pin_pend && cur_d.trig && !cur_d.mask && (any_wr || eoi_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RTE_RST;
      chg_q <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      chg_q <= chg_d;
      svc_q <= svc_d;
    end
  end

  assign rte      = cur_q;
  assign mask_chg = chg_q;
  assign svc      = svc_q;

endmodule

// File: rtl/irq_rf_rdmux.sv
module irq_rf_rdmux #(
  parameter int          NUM_PINS     = 24,
  parameter logic [7:0]  VERSION_CODE = 8'h20
) (
  input  logic        hit_sel,
  input  logic        hit_win,
  input  logic [7:0]  sel,
  input  logic [3:0]  id,
  input  logic        acc_id,
  input  logic        acc_ver,
  input  logic        acc_arb,
  input  logic        acc_rte,
  input  logic        rte_hi,
  input  logic [31:0] ent_lo,
  input  logic [31:0] ent_hi,
  output logic [31:0] word
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

  logic [31:0] win_word;

  always_comb begin
    win_word = 32'h0;
    if (acc_id || acc_arb) begin
      win_word = {4'b0, id, 24'b0};
    end else if (acc_ver) begin
      win_word = VER_WORD;
    end else if (acc_rte) begin
      win_word = rte_hi ? ent_hi : ent_lo;
    end
  end

  always_comb begin
    word = 32'h0;
    if (hit_sel) begin
      word = {24'b0, sel};
    end else if (hit_win) begin
      word = win_word;
    end
  end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile #(
  parameter int         NUM_PINS     = 24,
  parameter int         ADDR_W       = 8,
  parameter logic [7:0] VERSION_CODE = 8'h20,
  parameter int         OFS_SEL      = 'h00,
  parameter int         OFS_WIN      = 'h10,
  parameter int         OFS_EOI      = 'h40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  input  logic [NUM_PINS-1:0]         pin_pend,
  input  logic [NUM_PINS-1:0]         rirr_set,
  output logic [8*NUM_PINS-1:0]       rt_vector,
  output logic [3*NUM_PINS-1:0]       rt_dlv,
  output logic [NUM_PINS-1:0]         rt_dmode,
  output logic [NUM_PINS-1:0]         rt_pol,
  output logic [NUM_PINS-1:0]         rt_trig,
  output logic [NUM_PINS-1:0]         rt_mask,
  output logic [NUM_PINS-1:0]         rt_rirr,
  output logic [8*NUM_PINS-1:0]       rt_dest,
  output logic                        mask_evt,
  output logic [$clog2(NUM_PINS)-1:0] mask_evt_pin,
  output logic                        mask_evt_val,
  output logic [NUM_PINS-1:0]         svc_req
);
  import irq_rf_pkg::*;

  localparam int PIN_W = $clog2(NUM_PINS);

  // select, identification and read return registers
  logic [7:0]  sel_q, sel_d;
  logic [3:0]  id_q, id_d;
  logic [31:0] rdata_q;
  logic        rvalid_q;

  logic             hit_sel, hit_win;
  logic             sel_wr, win_wr, eoi_wr;
  logic             acc_id, acc_ver, acc_arb, acc_rte, rte_hi;
  logic [PIN_W-1:0] rte_idx;
  logic [31:0]      rd_word;

  rte_t              rte_arr [NUM_PINS];
  logic [NUM_PINS-1:0] chg_vec;
  rte_t              ent_sel;

  irq_rf_decode #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .OFS_SEL  (OFS_SEL),
    .OFS_WIN  (OFS_WIN),
    .OFS_EOI  (OFS_EOI),
    .PIN_W    (PIN_W)
  ) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .sel      (sel_q),
    .hit_sel  (hit_sel),
    .hit_win  (hit_win),
    .sel_wr   (sel_wr),
    .win_wr   (win_wr),
    .eoi_wr   (eoi_wr),
    .acc_id   (acc_id),
    .acc_ver  (acc_ver),
    .acc_arb  (acc_arb),
    .acc_rte  (acc_rte),
    .rte_hi   (rte_hi),
    .rte_idx  (rte_idx)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic sel_me;
    assign sel_me = win_wr && acc_rte && (rte_idx == PIN_W'(g));

    irq_rf_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (sel_me && !rte_hi),
      .wr_hi    (sel_me && rte_hi),
      .wdata    (bus_wdata),
      .eoi_wr   (eoi_wr),
      .eoi_vec  (bus_wdata[7:0]),
      .rirr_set (rirr_set[g]),
      .pin_pend (pin_pend[g]),
      .rte      (rte_arr[g]),
      .mask_chg (chg_vec[g]),
      .svc      (svc_req[g])
    );

    assign rt_vector[8*g +: 8] = rte_arr[g].vector;
    assign rt_dlv[3*g +: 3]    = rte_arr[g].dlv;
    assign rt_dmode[g]         = rte_arr[g].dmode;
    assign rt_pol[g]           = rte_arr[g].pol;
    assign rt_trig[g]          = rte_arr[g].trig;
    assign rt_mask[g]          = rte_arr[g].mask;
    assign rt_rirr[g]          = rte_arr[g].rirr;
    assign rt_dest[8*g +: 8]   = rte_arr[g].dest;
  end

  assign ent_sel = acc_rte ? rte_arr[rte_idx] : RTE_RST;

  irq_rf_rdmux #(
    .NUM_PINS     (NUM_PINS),
    .VERSION_CODE (VERSION_CODE)
  ) u_rdmux (
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .sel     (sel_q),
    .id      (id_q),
    .acc_id  (acc_id),
    .acc_ver (acc_ver),
    .acc_arb (acc_arb),
    .acc_rte (acc_rte),
    .rte_hi  (rte_hi),
    .ent_lo  (rte_lo_word(ent_sel)),
    .ent_hi  (rte_hi_word(ent_sel)),
    .word    (rd_word)
  );

  // next state of the control registers
  always_comb begin
    sel_d = sel_q;
    id_d  = id_q;
    if (sel_wr) begin
      sel_d = bus_wdata[7:0];
    end
    if (win_wr && acc_id) begin
      id_d = bus_wdata[27:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 8'h00;
      id_q     <= 4'h0;
      rvalid_q <= 1'b0;
      rdata_q  <= 32'h0;
    end else begin
      sel_q    <= sel_d;
      id_q     <= id_d;
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        rdata_q <= rd_word;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // at most one entry is written per cycle, so the event carries one pin
  always_comb begin
    mask_evt_pin = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (chg_vec[i]) begin
        mask_evt_pin = PIN_W'(i);
      end
    end
  end

  assign mask_evt     = |chg_vec;
  assign mask_evt_val = rt_mask[mask_evt_pin];

endmodule

// File: rtl/irq_rf_checker.sv
module irq_rf_checker #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_rvalid,
  input logic                win_wr,
  input logic                eoi_wr,
  input logic                acc_rte,
  input logic                rte_hi,
  input logic [PIN_W-1:0]    rte_idx,
  input logic [NUM_PINS-1:0] rt_rirr,
  input logic [NUM_PINS-1:0] rt_mask,
  input logic [8*NUM_PINS-1:0] rt_vector,
  input logic [8*NUM_PINS-1:0] rt_dest,
  input logic                mask_evt,
  input logic [NUM_PINS-1:0] svc_req
);

  p_rvalid_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_only_after_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_low_write_clears_rirr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && acc_rte && !rte_hi) |=> !rt_rirr[$past(rte_idx)]);

  p_oob_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !acc_rte) |=> ($stable(rt_vector) && $stable(rt_dest) && $stable(rt_mask)));

  p_mask_evt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(win_wr && acc_rte && !rte_hi));

  p_mask_evt_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> (rt_mask != $past(rt_mask)));

  p_svc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> $past(win_wr || eoi_wr));

  p_svc_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> ((svc_req & rt_mask) == '0));

endmodule

bind irq_route_regfile irq_rf_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .win_wr     (win_wr),
  .eoi_wr     (eoi_wr),
  .acc_rte    (acc_rte),
  .rte_hi     (rte_hi),
  .rte_idx    (rte_idx),
  .rt_rirr    (rt_rirr),
  .rt_mask    (rt_mask),
  .rt_vector  (rt_vector),
  .rt_dest    (rt_dest),
  .mask_evt   (mask_evt),
  .svc_req    (svc_req)
);

// File: tb/test_irq_route_regfile.sv
`timescale 1ns/1ps
module test_irq_route_regfile;

  localparam int         NP  = 6;
  localparam int         PW  = $clog2(NP);
  localparam logic [7:0] VER = 8'h21;
  localparam logic [7:0] A_SEL = 8'h00, A_WIN = 8'h10, A_EOI = 8'h40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_pend, rirr_set;
  logic [8*NP-1:0] rt_vector, rt_dest;
  logic [3*NP-1:0] rt_dlv;
  logic [NP-1:0] rt_dmode, rt_pol, rt_trig, rt_mask, rt_rirr, svc_req;
  logic          mask_evt, mask_evt_val;
  logic [PW-1:0] mask_evt_pin;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_lo [NP];
  logic [31:0] exp_hi [NP];
  logic [3:0]  exp_id;

  always #2 clk = ~clk;

  irq_route_regfile #(.NUM_PINS(NP), .ADDR_W(8), .VERSION_CODE(VER)) i_irq_route_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_pend(pin_pend), .rirr_set(rirr_set), .rt_vector(rt_vector), .rt_dlv(rt_dlv),
    .rt_dmode(rt_dmode), .rt_pol(rt_pol), .rt_trig(rt_trig), .rt_mask(rt_mask),
    .rt_rirr(rt_rirr), .rt_dest(rt_dest), .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin),
    .mask_evt_val(mask_evt_val), .svc_req(svc_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rwin(input logic [7:0] s, output logic [31:0] d);
    wr(A_SEL, {24'h0, s});
    rd(A_WIN, d);
  endtask

  task automatic wwin(input logic [7:0] s, input logic [31:0] d);
    wr(A_SEL, {24'h0, s});
    wr(A_WIN, d);
  endtask

  function automatic logic [31:0] exp_word(input int s);
    int idx;
    if (s == 0 || s == 2) return {4'b0, exp_id, 24'b0};
    if (s == 1) return {8'h00, 8'(NP - 1), 8'h00, VER};
    if (s < 16) return 32'h0;
    idx = (s - 16) >> 1;
    if (idx >= NP) return 32'h0;
    return (s % 2 == 1) ? exp_hi[idx] : exp_lo[idx];
  endfunction

  task automatic pulse_rirr(input int p);
    @(negedge clk);
    rirr_set[p] = 1'b1;
    @(negedge clk);
    rirr_set = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    pin_pend = '0; rirr_set = '0; exp_id = 4'h0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 masks", 32'(rt_mask), 32'(6'h3F));
    chk("R7 vectors", rt_vector[31:0], 32'h0);
    chk("R7 rvalid/evt/svc", {30'b0, bus_rvalid, mask_evt} | 32'(svc_req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(A_SEL, d);
    chk("R7 select after reset", d, 32'h0);
    // R12 registered read timing
    chk("R12 rvalid with data", 32'(bus_rvalid), 32'h1);
    @(negedge clk);
    chk("R12 rvalid drops", 32'(bus_rvalid), 32'h0);

    // R1 select keeps 8 bits
    wr(A_SEL, 32'h0000_01AB);
    rd(A_SEL, d);
    chk("R1 select width", d, 32'h0000_00AB);

    // R3 identification and arbitration selects
    wwin(8'h00, 32'hA5C3_1234);
    exp_id = 4'h5;
    rwin(8'h00, d); chk("R3 id read", d, 32'h0500_0000);
    wwin(8'h02, 32'h0F00_0000);
    rwin(8'h02, d); chk("R3 arb read, arb write ignored", d, 32'h0500_0000);

    // R2 version is read-only
    wwin(8'h01, 32'hFFFF_FFFF);
    rwin(8'h01, d); chk("R2 version", d, {8'h00, 8'(NP - 1), 8'h00, VER});

    // R4 program every entry
    for (int p = 0; p < NP; p++) begin
      w = 32'hFFFE_0000 | ((p * 32'h1357 + 32'h00A5) & 32'h0000_FFFF) | 32'h0001_0000;
      wwin(8'(16 + 2 * p), w);
      exp_lo[p] = w & 32'h0001_AFFF;
      w = {8'(p * 29 + 3), 24'hABCDEF};
      wwin(8'(17 + 2 * p), w);
      exp_hi[p] = w & 32'hFF00_0000;
      chk("R4 vector output", 32'(rt_vector[8*p +: 8]), 32'(exp_lo[p][7:0]));
      chk("R4 dest output", 32'(rt_dest[8*p +: 8]), 32'(exp_hi[p][31:24]));
      chk("R4 dlv/trig output", {28'b0, rt_dlv[3*p +: 3], rt_trig[p]},
          {28'b0, exp_lo[p][10:8], exp_lo[p][15]});
    end

    // R4 R6 full select sweep
    for (int s = 0; s < 256; s++) begin
      rwin(8'(s), d);
      if (s >= 16 && ((s - 16) >> 1) < NP) chk("R4 sweep entry", d, exp_word(s));
      else chk("R6 sweep other", d, exp_word(s));
    end

    // R6 writes beyond the last entry
    for (int s = 16 + 2 * NP; s < 256; s++) begin
      wwin(8'(s), 32'hFFFF_FFFF);
    end
    for (int s = 3; s < 16; s++) begin
      wwin(8'(s), 32'hFFFF_FFFF);
    end
    for (int p = 0; p < NP; p++) begin
      rwin(8'(16 + 2 * p), d); chk("R6 low unchanged", d, exp_lo[p]);
      rwin(8'(17 + 2 * p), d); chk("R6 high unchanged", d, exp_hi[p]);
    end
    rwin(8'h00, d); chk("R6 id unchanged", d, 32'h0500_0000);

    // R11 unmapped offsets
    wr(A_SEL, 32'h0000_0010);
    wr(8'h20, 32'h0000_0077);
    wr(8'h14, 32'h0000_0033);
    rd(A_SEL, d); chk("R11 select unchanged", d, 32'h0000_0010);
    rd(8'h20, d); chk("R11 read zero", d, 32'h0);
    rd(A_EOI, d); chk("R11 eoi read zero", d, 32'h0);
    rd(A_WIN, d); chk("R11 entry unchanged", d, exp_lo[0]);

    // R8 mask change events on pin 2
    wwin(8'h14, 32'h0000_0040);
    chk("R8 event on unmask", {29'b0, mask_evt, mask_evt_val, 1'b0} | 32'(mask_evt_pin) << 3,
        {29'b0, 1'b1, 1'b0, 1'b0} | 32'd2 << 3);
    @(negedge clk);
    chk("R8 event one cycle", 32'(mask_evt), 32'h0);
    wr(A_WIN, 32'h0000_0041);
    chk("R8 no event same mask", 32'(mask_evt), 32'h0);
    wr(A_WIN, 32'h0001_0041);
    chk("R8 event on mask", {30'b0, mask_evt, mask_evt_val}, 32'h3);
    chk("R8 event pin", 32'(mask_evt_pin), 32'd2);

    // R9 service after write
    pin_pend = 6'b111000;
    wwin(8'h16, 32'h0000_8055);   // pin 3 level, unmasked, vector 0x55
    chk("R9 level unmasked pending", 32'(svc_req), 32'h8);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(svc_req), 32'h0);
    wwin(8'h18, 32'h0000_0056);   // pin 4 edge, unmasked
    chk("R9 edge no service", 32'(svc_req), 32'h0);
    wwin(8'h1A, 32'h0001_8055);   // pin 5 level, masked, vector 0x55
    chk("R9 masked no service", 32'(svc_req), 32'h0);

    // R5 remote-pending flag
    wwin(8'h12, 32'h0001_8066);   // pin 1 level, masked, vector 0x66
    pulse_rirr(3);
    pulse_rirr(1);
    pulse_rirr(5);
    rwin(8'h16, d); chk("R5 rirr read bit 14", d, 32'h0000_C055);
    // R10 end-of-interrupt
    wr(A_EOI, 32'h0000_0055);
    chk("R10 service after eoi", 32'(svc_req), 32'h8);
    chk("R10 rirr cleared on match", 32'(rt_rirr), 32'h2);
    wwin(8'h13, 32'h1100_0000);
    chk("R5 high write keeps rirr", 32'(rt_rirr[1]), 32'h1);
    wwin(8'h12, 32'h0001_8066);
    chk("R5 low write clears rirr", 32'(rt_rirr[1]), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule